// File: doc/BRIEF.md
# Serial Memory Command Front End

This block sits between an SPI mode 0 master and the internals of a small serial nonvolatile memory. It samples the serial clock, select and data lines with the system clock, assembles bytes, and decodes a fixed set of six commands. Bytes arrive MSB first and are sampled on rising serial-clock edges. Each decoded action leaves the block as a single-cycle request. Two requests go to the memory array port: a read strobe, and a write request carrying a 14-bit address and a data byte. The rest go to the status and protection controller: latch set, latch clear, status read and status write.

Array reads and status reads return data MSB first, shifted out on falling serial-clock edges. An array read keeps streaming bytes from consecutive addresses for as long as select stays low. A write is only committed when select is released cleanly on a byte boundary after at least one data byte. Partial bytes and unknown opcodes have no effect.

Top module: `spimem_front`

## Requirements
- R1: Every byte is shifted in MSB first on rising serial-clock edges while select is low. An opcode is valid only when its upper four bits are zero. Bit 3 of the opcode is ignored, and the action is chosen by bits 2..0.
- R2: Opcode low bits 110 pulse `wel_set` and low bits 100 pulse `wel_clr`, each once, after the eighth opcode bit. Bytes that follow are ignored.
- R3: Opcode low bits 101 pulse `sts_rd_stb` after the opcode and again after each further complete byte. The `sts_rd_data` byte, valid the cycle after the strobe, is shifted out MSB first starting at the next falling edge.
- R4: Opcode low bits 011 (read) and 010 (write) take two address bytes, high byte first. The top two bits of the 16-bit field are ignored. For a read, `mem_rd_stb` pulses with `mem_addr` holding the address, and `mem_rd_data` is expected one cycle later. The byte is shifted out MSB first from the falling edge after the last address bit.
- R5: While select stays low during a read, the address advances by one after each byte shifted out, wrapping from 0x3FFF to 0x0000, and a new `mem_rd_stb` fetches the next byte.
- R6: For opcode low bits 010, `mem_wr_req` pulses once when select rises, but only if select rises on a byte boundary after at least one data byte. The request carries the last complete data byte on `mem_wr_data`. Its address on `mem_addr` is the start address plus the number of data bytes minus one, modulo 0x4000.
- R7: A write is dropped when select rises in the middle of a byte or before any data byte has arrived. Select rising in the middle of a byte discards that partial byte.
- R8: Opcode low bits 001 pulse `sts_wr_stb` with the last complete data byte on `sts_wr_data`, under the same commit rule as R6 and R7.
- R9: Opcodes with a nonzero upper nibble, or with low bits 000 or 111, produce no request and no output enable until select goes high again.
- R10: `spi_miso_oe` is high only while select is low and a read or status read is in its data phase. It drops within four clock cycles of select rising. After reset every output is zero.
- R11: All requests are single-cycle pulses, and at most one of them is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock from master |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data from master |
| spi_miso | output | 1 | Serial data to master |
| spi_miso_oe | output | 1 | Output enable for `spi_miso` |
| mem_addr | output | 14 | Array address for reads and writes |
| mem_rd_stb | output | 1 | Array read request |
| mem_rd_data | input | 8 | Array read data, valid the cycle after the strobe |
| mem_wr_req | output | 1 | Array write request |
| mem_wr_data | output | 8 | Array write data |
| sts_rd_stb | output | 1 | Status read request |
| sts_rd_data | input | 8 | Status byte, valid the cycle after the strobe |
| sts_wr_stb | output | 1 | Status write request |
| sts_wr_data | output | 8 | Status write data |
| wel_set | output | 1 | Set write-enable latch |
| wel_clr | output | 1 | Clear write-enable latch |

## Verification
The bench builds the block with its default 14-bit address and two-stage input synchronisers. It drives a serial clock of six system clocks per half period, which keeps the full opcode space within reach. All 256 opcode values are swept, each followed by one extra byte, and the request counts are compared against the decode rule. Reads and writes are aimed at the top of the address space so the wrap to zero is crossed. Writes are also cut short mid-byte and before any data byte to probe the commit rule.

// File: rtl/spimem_pkg.sv
package spimem_pkg;
  typedef enum logic [2:0] {
    PH_OPC,
    PH_ADDR,
    PH_RDATA,
    PH_SDATA,
    PH_WDATA,
    PH_SWDATA,
    PH_IGNORE
  } phase_t;

  localparam logic [2:0] OPL_WEL_SET = 3'b110;
  localparam logic [2:0] OPL_WEL_CLR = 3'b100;
  localparam logic [2:0] OPL_STS_RD  = 3'b101;
  localparam logic [2:0] OPL_STS_WR  = 3'b001;
  localparam logic [2:0] OPL_ARR_RD  = 3'b011;
  localparam logic [2:0] OPL_ARR_WR  = 3'b010;
endpackage

// File: rtl/spimem_sync.sv
module spimem_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sck,
  input  logic cs_n,
  input  logic mosi,
  output logic cs_n_s,
  output logic mosi_s,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_rise
);
  localparam int NSIG = 3;
  localparam logic [NSIG-1:0] IDLE_VAL = 3'b010; // {sck, cs_n, mosi}

  logic [NSIG-1:0] stg [STAGES];
  logic [NSIG-1:0] prev;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[g] <= IDLE_VAL;
      else if (g == 0) stg[g] <= {sck, cs_n, mosi};
      else stg[g] <= stg[(g == 0) ? 0 : g-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev <= IDLE_VAL;
    else prev <= stg[STAGES-1];
  end

  assign cs_n_s   = stg[STAGES-1][1];
  assign mosi_s   = stg[STAGES-1][0];
  assign sck_rise = stg[STAGES-1][2] & ~prev[2] & ~cs_n_s;
  assign sck_fall = ~stg[STAGES-1][2] & prev[2] & ~cs_n_s;
  assign cs_rise  = cs_n_s & ~prev[1];
endmodule

// File: rtl/spimem_rx.sv
module spimem_rx (
  input  logic       clk,
  input  logic       rst,
  input  logic       cs_n_s,
  input  logic       sck_rise,
  input  logic       mosi_s,
  output logic       byte_v,
  output logic [7:0] byte_q,
  output logic [2:0] bit_cnt
);
  logic [6:0] sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr <= '0; bit_cnt <= '0; byte_v <= 1'b0; byte_q <= '0;
    end else begin
      byte_v <= 1'b0;
      if (cs_n_s) begin
        sr <= '0;
        bit_cnt <= '0;
      end else if (sck_rise) begin
        sr <= {sr[5:0], mosi_s};
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          byte_v <= 1'b1;
          byte_q <= {sr, mosi_s};
        end
      end
    end
  end

  // R1: a byte is only delivered from bits sampled while selected
  p_byte_in_select_r1: assert property (@(posedge clk) disable iff (rst)
    byte_v |-> $past(!cs_n_s));
endmodule

// File: rtl/spimem_tx.sv
module spimem_tx (
  input  logic       clk,
  input  logic       rst,
  input  logic       cs_n_s,
  input  logic       sck_fall,
  input  logic       active,
  input  logic       load,
  input  logic [7:0] hold,
  output logic       miso,
  output logic       oe
);
  logic [7:0] sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr <= '0; miso <= 1'b0; oe <= 1'b0;
    end else begin
      oe <= active & ~cs_n_s;
      if (sck_fall && active) begin
        if (load) begin
          miso <= hold[7];
          sr   <= {hold[6:0], 1'b0};
        end else begin
          miso <= sr[7];
          sr   <= {sr[6:0], 1'b0};
        end
      end
    end
  end

  // R10: output enable falls once select is seen high
  p_oe_idle_r10: assert property (@(posedge clk) disable iff (rst)
    cs_n_s |=> !oe);
endmodule

// File: rtl/spimem_front.sv
module spimem_front
  import spimem_pkg::*;
#(
  parameter int ADDR_W      = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd_stb,
  input  logic [7:0]        mem_rd_data,
  output logic              mem_wr_req,
  output logic [7:0]        mem_wr_data,
  output logic              sts_rd_stb,
  input  logic [7:0]        sts_rd_data,
  output logic              sts_wr_stb,
  output logic [7:0]        sts_wr_data,
  output logic              wel_set,
  output logic              wel_clr
);
  localparam int ABYTES = (ADDR_W + 7) / 8;
  localparam int ACC_W  = 8 * ABYTES;
  localparam int ACNT_W = $clog2(ABYTES) + 1;

  logic cs_n_s, mosi_s, sck_rise, sck_fall, cs_rise;
  logic byte_v;
  logic [7:0] byte_q;
  logic [2:0] bit_cnt;

  phase_t phase;
  logic is_read, have_data, arr_pend, sts_pend;
  logic [ACNT_W-1:0] abyte;
  logic [ACC_W-1:0]  acc;
  logic [ACC_W-1:0]  acc_next;
  logic [7:0]        hold;

  spimem_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .sck(spi_sck), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .cs_n_s(cs_n_s), .mosi_s(mosi_s), .sck_rise(sck_rise),
    .sck_fall(sck_fall), .cs_rise(cs_rise)
  );

  spimem_rx u_rx (
    .clk(clk), .rst(rst), .cs_n_s(cs_n_s), .sck_rise(sck_rise),
    .mosi_s(mosi_s), .byte_v(byte_v), .byte_q(byte_q), .bit_cnt(bit_cnt)
  );

  spimem_tx u_tx (
    .clk(clk), .rst(rst), .cs_n_s(cs_n_s), .sck_fall(sck_fall),
    .active(phase == PH_RDATA || phase == PH_SDATA),
    .load(bit_cnt == 3'd0), .hold(hold),
    .miso(spi_miso), .oe(spi_miso_oe)
  );

  if (ABYTES > 1) begin : g_acc_multi
    assign acc_next = {acc[ACC_W-9:0], byte_q};
  end else begin : g_acc_single
    assign acc_next = byte_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_OPC; is_read <= 1'b0; have_data <= 1'b0;
      abyte <= '0; acc <= '0; hold <= '0;
      arr_pend <= 1'b0; sts_pend <= 1'b0;
      mem_addr <= '0; mem_rd_stb <= 1'b0; mem_wr_req <= 1'b0; mem_wr_data <= '0;
      sts_rd_stb <= 1'b0; sts_wr_stb <= 1'b0; sts_wr_data <= '0;
      wel_set <= 1'b0; wel_clr <= 1'b0;
    end else begin
      mem_rd_stb <= 1'b0; mem_wr_req <= 1'b0;
      sts_rd_stb <= 1'b0; sts_wr_stb <= 1'b0;
      wel_set <= 1'b0; wel_clr <= 1'b0;
      arr_pend <= mem_rd_stb;
      sts_pend <= sts_rd_stb;
      if (arr_pend) hold <= mem_rd_data;
      else if (sts_pend) hold <= sts_rd_data;

      if (cs_rise) begin
        if (have_data && bit_cnt == 3'd0) begin
          if (phase == PH_WDATA) mem_wr_req <= 1'b1;
          if (phase == PH_SWDATA) sts_wr_stb <= 1'b1;
        end
        phase <= PH_OPC; have_data <= 1'b0; abyte <= '0;
      end else if (cs_n_s) begin
        phase <= PH_OPC; have_data <= 1'b0; abyte <= '0;
      end else if (byte_v) begin
        unique case (phase)
          PH_OPC: begin
            phase <= PH_IGNORE;
            if (byte_q[7:4] == 4'h0) begin
              unique case (byte_q[2:0])
                OPL_WEL_SET: wel_set <= 1'b1;
                OPL_WEL_CLR: wel_clr <= 1'b1;
                OPL_STS_RD: begin sts_rd_stb <= 1'b1; phase <= PH_SDATA; end
                OPL_STS_WR: phase <= PH_SWDATA;
                OPL_ARR_RD: begin is_read <= 1'b1; phase <= PH_ADDR; end
                OPL_ARR_WR: begin is_read <= 1'b0; phase <= PH_ADDR; end
                default: phase <= PH_IGNORE;
              endcase
            end
          end
          PH_ADDR: begin
            acc <= acc_next;
            abyte <= abyte + 1'b1;
            if (abyte == ACNT_W'(ABYTES - 1)) begin
              mem_addr <= acc_next[ADDR_W-1:0];
              if (is_read) begin
                mem_rd_stb <= 1'b1;
                phase <= PH_RDATA;
              end else begin
                phase <= PH_WDATA;
              end
            end
          end
          PH_RDATA: begin
            mem_addr <= mem_addr + 1'b1;
            mem_rd_stb <= 1'b1;
          end
          PH_SDATA: sts_rd_stb <= 1'b1;
          PH_WDATA: begin
            if (have_data) mem_addr <= mem_addr + 1'b1;
            mem_wr_data <= byte_q;
            have_data <= 1'b1;
          end
          PH_SWDATA: begin
            sts_wr_data <= byte_q;
            have_data <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  p_strobes_onehot_r11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_rd_stb, mem_wr_req, sts_rd_stb, sts_wr_stb, wel_set, wel_clr}));
  p_wr_single_r6: assert property (@(posedge clk) disable iff (rst)
    mem_wr_req |=> !mem_wr_req);
  p_wr_on_release_r7: assert property (@(posedge clk) disable iff (rst)
    mem_wr_req |-> $past(cs_rise));
  p_sts_wr_on_release_r8: assert property (@(posedge clk) disable iff (rst)
    sts_wr_stb |-> $past(cs_rise));
endmodule

// File: tb/tb_spimem_front.sv
module tb_spimem_front;
  localparam int H = 6;

  logic clk = 0, rst = 1;
  logic sck = 0, cs_n = 1, mosi = 0;
  logic miso, oe, mem_rd_stb, mem_wr_req, sts_rd_stb, sts_wr_stb, wel_set, wel_clr;
  logic [13:0] mem_addr;
  logic [7:0] mem_rd_data = 0, mem_wr_data, sts_wr_data, sts_rd_data = 8'hC6;

  int checks = 0, fails = 0;
  int n_rd = 0, n_wr = 0, n_srd = 0, n_swr = 0, n_set = 0, n_clr = 0, n_oe = 0;
  logic [13:0] last_wa = 0;
  logic [7:0]  last_wd = 0, last_sd = 0;
  bit done = 0;

  always #5 clk = ~clk;

  spimem_front dut (
    .clk(clk), .rst(rst), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .spi_miso_oe(oe), .mem_addr(mem_addr), .mem_rd_stb(mem_rd_stb),
    .mem_rd_data(mem_rd_data), .mem_wr_req(mem_wr_req), .mem_wr_data(mem_wr_data),
    .sts_rd_stb(sts_rd_stb), .sts_rd_data(sts_rd_data), .sts_wr_stb(sts_wr_stb),
    .sts_wr_data(sts_wr_data), .wel_set(wel_set), .wel_clr(wel_clr)
  );

  function automatic logic [7:0] pat(input logic [13:0] a);
    return a[7:0] ^ {a[13:8], 2'b01};
  endfunction

  always @(posedge clk) begin
    if (mem_rd_stb) mem_rd_data <= pat(mem_addr);
    if (!rst) begin
      if (mem_rd_stb) n_rd++;
      if (mem_wr_req) begin n_wr++; last_wa = mem_addr; last_wd = mem_wr_data; end
      if (sts_rd_stb) n_srd++;
      if (sts_wr_stb) begin n_swr++; last_sd = sts_wr_data; end
      if (wel_set) n_set++;
      if (wel_clr) n_clr++;
      if (oe) n_oe++;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic clear_counts();
    n_rd = 0; n_wr = 0; n_srd = 0; n_swr = 0; n_set = 0; n_clr = 0; n_oe = 0;
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sel();
    cs_n = 0; wait_clk(H);
  endtask

  task automatic desel();
    wait_clk(H); cs_n = 1; wait_clk(10);
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx, input int nbits = 8);
    rx = 0;
    for (int i = 7; i > 7 - nbits; i--) begin
      mosi = tx[i];
      wait_clk(H);
      rx[i] = miso;
      sck = 1;
      wait_clk(H);
      sck = 0;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    logic [7:0] rx;
    logic [13:0] a;
    wait_clk(5);
    rst = 0;
    wait_clk(1);
    // R10: reset state
    check("R10 reset outputs", {oe, mem_rd_stb, mem_wr_req, sts_rd_stb, sts_wr_stb, wel_set, wel_clr}, 0);
    check("R10 reset addr", mem_addr, 0);

    // R1 R2 R3 R8 R9 R11: full opcode sweep, opcode plus one extra byte
    for (int op = 0; op < 256; op++) begin
      int es, ec, er, ew, eo;
      clear_counts();
      sel(); xfer(op[7:0], rx); xfer(8'h5A, rx); desel();
      es = 0; ec = 0; er = 0; ew = 0; eo = 0;
      if (op[7:4] == 0) begin
        case (op[2:0])
          3'b110: es = 1;
          3'b100: ec = 1;
          3'b101: begin er = 2; eo = 1; end
          3'b001: ew = 1;
          default: ;
        endcase
      end
      check($sformatf("R2 set op %0h", op), n_set, es);
      check($sformatf("R2 clr op %0h", op), n_clr, ec);
      check($sformatf("R3 srd op %0h", op), n_srd, er);
      check($sformatf("R8 swr op %0h", op), n_swr, ew);
      check($sformatf("R9 rd/wr none op %0h", op), n_rd + n_wr, 0);
      check($sformatf("R10 oe op %0h", op), (n_oe > 0) ? 1 : 0, eo);
      if (ew == 1) check($sformatf("R8 swr data op %0h", op), last_sd, 8'h5A);
    end

    // R3: status byte returned twice MSB first
    sel(); xfer(8'h05, rx); xfer(8'h00, rx);
    check("R3 status byte 1", rx, 8'hC6);
    xfer(8'h00, rx);
    check("R3 status byte 2", rx, 8'hC6);
    desel();

    // R4 R5: reads with top address bits set, crossing the wrap; bit3 set opcode (R1)
    for (int t = 0; t < 3; t++) begin
      logic [15:0] start;
      start = (t == 0) ? 16'hFFFE : (t == 1) ? 16'h0123 : 16'h3FFF;
      clear_counts();
      sel();
      xfer((t == 1) ? 8'h0B : 8'h03, rx);
      xfer(start[15:8], rx); xfer(start[7:0], rx);
      for (int k = 0; k < 4; k++) begin
        a = start[13:0] + 14'(k);
        xfer(8'h00, rx);
        check($sformatf("R5 read byte %0d start %0h", k, start), rx, pat(a));
      end
      check("R10 oe high during read", oe, 1);
      desel();
      check("R10 oe low after release", oe, 0);
      check("R4 read strobes", n_rd, 5);
    end

    // R6: write three bytes from 0x3FFF, wraps to 0x0001
    clear_counts();
    sel(); xfer(8'h0A, rx); xfer(8'hFF, rx); xfer(8'hFF, rx);
    xfer(8'h11, rx); xfer(8'h22, rx); xfer(8'h33, rx); desel();
    check("R6 write count", n_wr, 1);
    check("R6 write addr", last_wa, 14'h0001);
    check("R6 write data", last_wd, 8'h33);

    // R6: single byte at 0x1234 with top bits set in field
    clear_counts();
    sel(); xfer(8'h02, rx); xfer(8'hD2, rx); xfer(8'h34, rx); xfer(8'h9C, rx); desel();
    check("R6 single write count", n_wr, 1);
    check("R6 single write addr", last_wa, 14'h1234);
    check("R6 single write data", last_wd, 8'h9C);

    // R7: no data byte, then partial byte after a full one
    clear_counts();
    sel(); xfer(8'h02, rx); xfer(8'h00, rx); xfer(8'h10, rx); desel();
    check("R7 write with no data", n_wr, 0);
    sel(); xfer(8'h02, rx); xfer(8'h00, rx); xfer(8'h10, rx);
    xfer(8'h77, rx); xfer(8'h88, rx, 4); desel();
    check("R7 write ended mid byte", n_wr, 0);
    sel(); xfer(8'h01, rx); xfer(8'h44, rx); xfer(8'h55, rx, 3); desel();
    check("R8 status write ended mid byte", n_swr, 0);
    // R7: partial bits discarded; next command decodes cleanly
    sel(); xfer(8'h06, rx, 5); desel();
    sel(); xfer(8'h06, rx); desel();
    check("R7 partial opcode discarded", n_set, 1);

    finish_up();
  end
endmodule